// File: doc/BRIEF.md
# Single-Item Coin Vending Controller

The block is a synchronous controller for a machine that sells one item at a price of 10 units. Four active-low push buttons drive it: a 5-unit coin, a 10-unit coin, confirm, and cancel. Each button passes through its own synchronizer and falling-edge detector, which turns one press into one single-clock event. The controller keeps a running credit in steps of 5 units, up to a ceiling of 15.

On a confirm with at least the price in credit, the block sells the item. It raises a purchase strobe for one clock and reports any change. On a cancel, it returns the whole credit. The credit and the refund/change value are exposed as plain binary words, ready for a display or for coin-return logic.

The refund value stays on its output until the next accepted button event. When several presses land in the same clock, a fixed priority picks one of them.

Top module: `vend_ctrl_top`

## Requirements
- R1: After reset (rst_ni low), credit_o is 0, change_o is 0 and vend_o is 0.
- R2: A 5-unit coin event adds 5 to credit_o and a 10-unit coin event adds 10, with change_o cleared to 0. credit_o is always a multiple of 5.
- R3: A coin event that would raise the credit above 15 is ignored: credit_o keeps its value and vend_o stays 0. change_o is cleared to 0, because the event still counts as an event.
- R4: A confirm event with credit 10 raises vend_o for exactly one clock and clears credit_o to 0 on that clock. change_o becomes 0.
- R5: A confirm event with credit 15 raises vend_o for one clock, clears credit_o to 0 and sets change_o to 5.
- R6: A confirm event with credit 0 or 5 does not sell. vend_o stays 0, credit_o is unchanged and change_o is cleared to 0.
- R7: A cancel event sets change_o to the credit held before it, clears credit_o to 0 and leaves vend_o at 0.
- R8: With no button event, credit_o and change_o hold their values.
- R9: When several events occur in the same clock, only one is acted on. The priority is cancel first, then confirm, then the 10-unit coin, then the 5-unit coin.
- R10: Each button is active-low. A press that stays low yields exactly one event. A button that returns high yields none. The effect of a press shows on the outputs on the second rising clock edge after the first edge that samples the button low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coin_lo_ni | input | 1 | 5-unit coin button, active low |
| coin_hi_ni | input | 1 | 10-unit coin button, active low |
| confirm_ni | input | 1 | Confirm button, active low |
| cancel_ni | input | 1 | Cancel button, active low |
| vend_o | output | 1 | Purchase strobe, one clock per sale |
| credit_o | output | 4 | Credit currently held, in units |
| change_o | output | 4 | Refund or change value from the last event |

## Verification
The bench builds the block with its default parameters: a 4-bit amount width, a price of 10, coins of 5 and 10, a ceiling of 15 and two synchronizer stages. With these values the ceiling is reached in two coins, so rejected overflow coins, 15-unit sales with change, and cancels at every credit level all come up within a few presses.

Random press patterns include simultaneous presses of two to four buttons, which exercises the priority order. Directed sequences cover confirming at 0 and at 5. After each release the bench checks that nothing changed, to show that rising edges and long presses create no extra events.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int BTN_N       = 4;
  localparam int BTN_COIN_LO = 0;
  localparam int BTN_COIN_HI = 1;
  localparam int BTN_CONFIRM = 2;
  localparam int BTN_CANCEL  = 3;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_COIN_LO,
    EV_COIN_HI,
    EV_CONFIRM,
    EV_CANCEL
  } vend_ev_e;
endpackage

// File: rtl/vend_btn_edge.sv
module vend_btn_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= btn_ni;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], btn_ni};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[SYNC_STAGES-1];

  // high-to-low on the synchronized line
  assign pulse_o = prev_q & ~sync_q[SYNC_STAGES-1];

  p_pulse_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/vend_ev_arb.sv
module vend_ev_arb
  import vend_pkg::*;
(
  input  logic [BTN_N-1:0] pulse_i,
  output vend_ev_e         ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if      (pulse_i[BTN_CANCEL])  ev_o = EV_CANCEL;
    else if (pulse_i[BTN_CONFIRM]) ev_o = EV_CONFIRM;
    else if (pulse_i[BTN_COIN_HI]) ev_o = EV_COIN_HI;
    else if (pulse_i[BTN_COIN_LO]) ev_o = EV_COIN_LO;
  end

  always_comb begin
    if (pulse_i != '0) p_any_event_r9: assert (ev_o != EV_NONE);
  end
endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
  import vend_pkg::*;
#(
  parameter int AMT_W       = 4,
  parameter int PRICE       = 10,
  parameter int COIN_LO_VAL = 5,
  parameter int COIN_HI_VAL = 10,
  parameter int CREDIT_MAX  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  vend_ev_e         ev_i,
  output logic             vend_o,
  output logic [AMT_W-1:0] credit_o,
  output logic [AMT_W-1:0] change_o
);
  localparam int EXT_W = AMT_W + 1;
  localparam logic [EXT_W-1:0] LO_X    = EXT_W'(COIN_LO_VAL);
  localparam logic [EXT_W-1:0] HI_X    = EXT_W'(COIN_HI_VAL);
  localparam logic [EXT_W-1:0] MAX_X   = EXT_W'(CREDIT_MAX);
  localparam logic [AMT_W-1:0] PRICE_A = AMT_W'(PRICE);

  logic [AMT_W-1:0] credit_q, credit_d, change_q, change_d;
  logic             vend_q, vend_d;
  logic [EXT_W-1:0] sum_lo, sum_hi;

  assign sum_lo = {1'b0, credit_q} + LO_X;
  assign sum_hi = {1'b0, credit_q} + HI_X;

  always_comb begin
    credit_d = credit_q;
    change_d = change_q;
    vend_d   = 1'b0;
    unique case (ev_i)
      EV_CANCEL: begin
        change_d = credit_q;
        credit_d = '0;
      end
      EV_CONFIRM: begin
        change_d = '0;
        if (credit_q >= PRICE_A) begin
          vend_d   = 1'b1;
          change_d = credit_q - PRICE_A;
          credit_d = '0;
        end
      end
      EV_COIN_HI: begin
        change_d = '0;
        if (sum_hi <= MAX_X) credit_d = sum_hi[AMT_W-1:0];
      end
      EV_COIN_LO: begin
        change_d = '0;
        if (sum_lo <= MAX_X) credit_d = sum_lo[AMT_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      credit_q <= '0;
      change_q <= '0;
      vend_q   <= 1'b0;
    end else begin
      credit_q <= credit_d;
      change_q <= change_d;
      vend_q   <= vend_d;
    end

  assign vend_o   = vend_q;
  assign credit_o = credit_q;
  assign change_o = change_q;

  p_credit_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, credit_q} <= MAX_X);
  p_credit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(credit_q) % COIN_LO_VAL) == 0);
  p_vend_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vend_q |=> !vend_q);
  p_vend_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vend_q |-> credit_q == '0);
  p_cancel_refund_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_CANCEL |=> credit_q == '0 && !vend_q && change_q == $past(credit_q));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_NONE |=> $stable(credit_q) && $stable(change_q) && !vend_q);
  p_low_confirm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_CONFIRM && credit_q < PRICE_A) |=> !vend_q && $stable(credit_q));
endmodule

// File: rtl/vend_ctrl_top.sv
module vend_ctrl_top
  import vend_pkg::*;
#(
  parameter int AMT_W       = 4,
  parameter int PRICE       = 10,
  parameter int COIN_LO_VAL = 5,
  parameter int COIN_HI_VAL = 10,
  parameter int CREDIT_MAX  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             coin_lo_ni,
  input  logic             coin_hi_ni,
  input  logic             confirm_ni,
  input  logic             cancel_ni,
  output logic             vend_o,
  output logic [AMT_W-1:0] credit_o,
  output logic [AMT_W-1:0] change_o
);
  logic [BTN_N-1:0] btn_n, pulse;
  vend_ev_e         ev;

  always_comb begin
    btn_n              = '1;
    btn_n[BTN_COIN_LO] = coin_lo_ni;
    btn_n[BTN_COIN_HI] = coin_hi_ni;
    btn_n[BTN_CONFIRM] = confirm_ni;
    btn_n[BTN_CANCEL]  = cancel_ni;
  end

  for (genvar g = 0; g < BTN_N; g++) begin : g_btn
    vend_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .btn_ni (btn_n[g]),
      .pulse_o(pulse[g])
    );
  end

  vend_ev_arb u_arb (
    .pulse_i(pulse),
    .ev_o   (ev)
  );

  vend_credit_fsm #(
    .AMT_W      (AMT_W),
    .PRICE      (PRICE),
    .COIN_LO_VAL(COIN_LO_VAL),
    .COIN_HI_VAL(COIN_HI_VAL),
    .CREDIT_MAX (CREDIT_MAX)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .vend_o  (vend_o),
    .credit_o(credit_o),
    .change_o(change_o)
  );
endmodule

// File: tb/vend_ctrl_top_tb.sv
module vend_ctrl_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coin_lo_n = 1'b1, coin_hi_n = 1'b1, confirm_n = 1'b1, cancel_n = 1'b1;
  logic       vend;
  logic [3:0] credit, change;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_credit = 0, m_change = 0, m_vend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vend_ctrl_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .coin_lo_ni(coin_lo_n), .coin_hi_ni(coin_hi_n),
    .confirm_ni(confirm_n), .cancel_ni(cancel_n),
    .vend_o(vend), .credit_o(credit), .change_o(change)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mask bits: 0 coin5, 1 coin10, 2 confirm, 3 cancel
  function automatic string tag_of(logic [3:0] m, int cr);
    string t;
    if (m[3])      t = "R7 cancel";
    else if (m[2]) t = (cr == 15) ? "R5 confirm15" : (cr == 10) ? "R4 confirm10" : "R6 confirm-low";
    else if (m[1]) t = (cr + 10 > 15) ? "R3 coin10-overflow" : "R2 coin10";
    else           t = (cr + 5 > 15) ? "R3 coin5-overflow" : "R2 coin5";
    if ($countones(m) > 1) t = {"R9 priority/", t};
    return t;
  endfunction

  task automatic model_step(logic [3:0] m);
    m_vend = 0;
    if (m[3]) begin
      m_change = m_credit; m_credit = 0;
    end else if (m[2]) begin
      m_change = 0;
      if (m_credit >= 10) begin
        m_vend = 1; m_change = m_credit - 10; m_credit = 0;
      end
    end else if (m[1]) begin
      m_change = 0;
      if (m_credit + 10 <= 15) m_credit += 10;
    end else if (m[0]) begin
      m_change = 0;
      if (m_credit + 5 <= 15) m_credit += 5;
    end
  endtask

  task automatic press(logic [3:0] m);
    string t;
    t = tag_of(m, m_credit);
    @(negedge clk);
    coin_lo_n = ~m[0]; coin_hi_n = ~m[1]; confirm_n = ~m[2]; cancel_n = ~m[3];
    model_step(m);
    // R10: sampled low at edge k, outputs update at edge k+2
    @(negedge clk);
    chk({t, " R10 no early update vend"}, vend, 0);
    repeat (2) @(negedge clk);
    chk({t, " vend"}, vend, m_vend);
    chk({t, " credit"}, credit, m_credit);
    chk({t, " change"}, change, m_change);
    @(negedge clk);
    chk({t, " R4 vend one clock"}, vend, 0);
    repeat (3) @(negedge clk);
    coin_lo_n = 1'b1; coin_hi_n = 1'b1; confirm_n = 1'b1; cancel_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10/R8 release gives no event credit", credit, m_credit);
    chk("R10/R8 release gives no event change", change, m_change);
    chk("R10 release vend", vend, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset vend", vend, 0);
    chk("R1 reset credit", credit, 0);
    chk("R1 reset change", change, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release credit", credit, 0);

    // directed corners
    press(4'b0100);  // confirm at 0
    press(4'b0001);  // 5
    press(4'b0100);  // confirm at 5
    press(4'b0001);  // 10
    press(4'b0100);  // sale, change 0
    press(4'b0010);  // 10
    press(4'b0001);  // 15
    press(4'b0001);  // overflow 5
    press(4'b0010);  // overflow 10
    press(4'b0100);  // sale, change 5
    press(4'b0001);  // coin clears change
    press(4'b1000);  // cancel at 5
    press(4'b1000);  // cancel at 0
    press(4'b0010);
    press(4'b1111);  // all at once: cancel wins
    press(4'b0010);
    press(4'b0110);  // confirm over coin10
    press(4'b0011);  // coin10 over coin5
    press(4'b0101);  // confirm at 10 over coin5
    press(4'b0001);
    press(4'b0010);
    press(4'b1100);  // cancel over confirm at 15

    for (int i = 0; i < 400; i++) begin
      logic [3:0] m;
      if ($urandom_range(0, 9) < 6) m = 4'b0001 << $urandom_range(0, 3);
      else                           m = 4'($urandom_range(1, 15));
      press(m);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule